// File: doc/BRIEF.md
# RMII Receive Frame Filter

This block sits behind a two-bit reduced media-independent interface on the receive side of an Ethernet MAC. It rebuilds bytes from the dibit stream, finds the start of each frame behind its lead-in of `0x55` bytes and the `0xD5` delimiter, and streams the frame body into a byte-wide receive ring. Only frames that pass every check become visible to software. A frame counts as good when its destination address equals a fixed local address, its CRC-32 is correct, no receive error was flagged, it ends on a byte boundary and it fits in the free part of the ring.

Bytes go to the ring at a tentative address while the frame arrives. The write pointer that software sees moves only once the whole frame has been accepted. A rejected frame leaves the pointer where it was, and the tentative address falls back to it. Software consumes data from its read pointer. The block computes the free room from that pointer and never writes into unread bytes. The ring size in bytes is a power of two chosen when the block is built.

Top module: `rmii_rx_filter`

## Requirements
- R1: After reset the committed write pointer is 0 and no memory write is issued.
- R2: A byte is assembled from four consecutive dibits, the first dibit forming bits 1:0. The `0x55` lead-in bytes and the `0xD5` delimiter are never stored. The bytes after the delimiter, minus the last four, are written in order to consecutive ring addresses starting at the committed write pointer.
- R3: A memory write only ever targets the free region. The write's offset above the committed pointer, modulo the ring size, is below (read pointer - write pointer - 1) modulo the ring size.
- R4: The committed write pointer changes only at the end of an accepted frame, and then advances by the frame length minus the 4 check bytes. The new value is visible in the cycle after the first rising edge at which carrier/data-valid is sampled low.
- R5: A frame whose first 6 bytes after the delimiter differ from the local address (first byte = bits 47:40 of the address parameter) is discarded.
- R6: A frame whose last 4 bytes are not the complemented reflected CRC-32 (polynomial 0x04C11DB7, initial all-ones, least significant byte sent first) of the bytes before them is discarded. Equivalently, the CRC over all bytes leaves the residue 0xC704DD7B in most-significant-first form.
- R7: A frame during which the receive-error input is high while carrier/data-valid is high is discarded.
- R8: A frame whose stored length exceeds the free room is discarded silently. A frame whose stored length equals the free room exactly is accepted.
- R9: A frame shorter than 10 bytes after the delimiter, or ending with a partial byte, is discarded.
- R10: After any discarded frame, the next accepted frame is stored starting at the unchanged committed write pointer.
- R11: Ring addresses and the write pointer wrap modulo the ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| crsDv | input | 1 | Combined carrier sense and receive data valid |
| rxErr | input | 1 | Receive error from the PHY |
| rxd | input | 2 | Receive dibit |
| swRdPtr | input | PTR_W | Software read pointer into the ring |
| memWe | output | 1 | Ring memory write enable |
| memAddr | output | PTR_W | Ring memory byte address |
| memData | output | 8 | Ring memory write data |
| wrPtr | output | PTR_W | Committed hardware write pointer |

## Verification
The memory write for a byte is issued in the cycle after the rising edge that completes the byte four positions later. The check bytes are therefore never written. The committed pointer takes its new value on the first rising edge that samples carrier/data-valid low, and it holds steady at every other edge. The bench drives each dibit on a falling edge. At every falling edge, before it drives anything, it compares the pointer with a model value updated at that edge and records each write. Stored bytes are compared a few idle cycles after each frame ends, once all writes have landed.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  // Reflected CRC-32 residue after data plus a correct check field.
  localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;
  localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
  localparam logic [7:0]  SFD_BYTE         = 8'hD5;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_RECV,
    ST_DROP
  } rxStateT;

  // Control to datapath strobes.
  typedef struct packed {
    logic start;
    logic run;
    logic commit;
    logic abort;
  } rxCtlT;

  // Datapath to control status.
  typedef struct packed {
    logic sfdHit;
    logic macMiss;
    logic noRoom;
    logic frameOk;
  } rxStatT;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rmii_rx_dp.sv
module rmii_rx_dp
  import rmii_rx_pkg::*;
#(
  parameter int          RING_BYTES = 2048,
  parameter logic [47:0] LOCAL_MAC  = 48'hAABBCCDDEEFF,
  parameter int          PTR_W      = $clog2(RING_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             crsDv,
  input  logic [1:0]       rxd,
  input  logic [PTR_W-1:0] swRdPtr,
  input  rxCtlT            ctl,
  output rxStatT           stat,
  output logic             memWe,
  output logic [PTR_W-1:0] memAddr,
  output logic [7:0]       memData,
  output logic [PTR_W-1:0] wrPtr
);

  localparam int CNT_W     = 4;
  localparam int MAC_BYTES = 6;
  localparam int FCS_BYTES = 4;
  localparam int MIN_BYTES = MAC_BYTES + FCS_BYTES;

  logic [7:0]       sh;
  logic [7:0]       nb;
  logic [1:0]       phase;
  logic [CNT_W-1:0] byteCnt;
  logic [31:0]      crc;
  logic [FCS_BYTES-1:0][7:0] pipe;
  logic [PTR_W-1:0] tentPtr;
  logic [PTR_W-1:0] used;
  logic [PTR_W-1:0] free;
  logic [7:0]       macBytes [8];
  logic             phaseEnd;

  for (genvar i = 0; i < 8; i++) begin : g_mac
    if (i < MAC_BYTES) begin : g_real
      assign macBytes[i] = LOCAL_MAC[47-8*i -: 8];
    end else begin : g_pad
      assign macBytes[i] = 8'h00;
    end
  end

  assign nb       = {rxd, sh[7:2]};
  assign phaseEnd = (phase == 2'd3);
  assign used     = PTR_W'(tentPtr - wrPtr);
  assign free     = PTR_W'(swRdPtr - wrPtr - PTR_W'(1));

  always_comb begin
    stat.sfdHit  = (nb == SFD_BYTE);
    stat.macMiss = phaseEnd && (byteCnt < CNT_W'(MAC_BYTES)) &&
                   (nb != macBytes[byteCnt[2:0]]);
    stat.noRoom  = phaseEnd && (byteCnt >= CNT_W'(FCS_BYTES)) && (used == free);
    stat.frameOk = (phase == 2'd0) && (byteCnt >= CNT_W'(MIN_BYTES)) &&
                   (crc == CRC_RESIDUE_REFL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh      <= '0;
      phase   <= '0;
      byteCnt <= '0;
      crc     <= '1;
      pipe    <= '0;
      tentPtr <= '0;
      wrPtr   <= '0;
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      sh    <= crsDv ? nb : '0;
      memWe <= 1'b0;
      if (ctl.start) begin
        phase   <= '0;
        byteCnt <= '0;
        crc     <= '1;
      end else if (ctl.run) begin
        phase <= phase + 2'd1;
        if (phaseEnd) begin
          crc  <= crcByte(crc, nb);
          pipe <= {pipe[FCS_BYTES-2:0], nb};
          if (byteCnt != '1) byteCnt <= byteCnt + CNT_W'(1);
          if (byteCnt >= CNT_W'(FCS_BYTES)) begin
            memWe   <= 1'b1;
            memAddr <= tentPtr;
            memData <= pipe[FCS_BYTES-1];
            tentPtr <= tentPtr + PTR_W'(1);
          end
        end
      end
      if (ctl.commit) wrPtr   <= tentPtr;
      if (ctl.abort)  tentPtr <= wrPtr;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (PTR_W'(memAddr - wrPtr) < free));

  p_commit_only_on_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr != $past(wrPtr)) |-> $past(ctl.commit));

  p_rollback_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> (tentPtr == wrPtr));

endmodule

// File: rtl/rmii_rx_ctl.sv
module rmii_rx_ctl
  import rmii_rx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   crsDv,
  input  logic   rxErr,
  input  rxStatT stat,
  output rxCtlT  ctl
);

  rxStateT state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_HUNT: begin
        if (crsDv && stat.sfdHit) begin
          ctl.start = 1'b1;
          stateNext = ST_RECV;
        end
      end
      ST_RECV: begin
        if (!crsDv) begin
          ctl.commit = stat.frameOk;
          ctl.abort  = !stat.frameOk;
          stateNext  = ST_HUNT;
        end else if (rxErr || stat.macMiss || stat.noRoom) begin
          ctl.abort = 1'b1;
          stateNext = ST_DROP;
        end else begin
          ctl.run = 1'b1;
        end
      end
      ST_DROP: begin
        if (!crsDv) stateNext = ST_HUNT;
      end
      default: stateNext = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= stateNext;
  end

  p_err_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV && crsDv && rxErr) |=> (state == ST_DROP));

  p_mac_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV && crsDv && stat.macMiss) |=> (state == ST_DROP));

  p_bad_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV && !crsDv && !stat.frameOk) |-> (ctl.abort && !ctl.commit));

endmodule

// File: rtl/rmii_rx_filter.sv
module rmii_rx_filter
  import rmii_rx_pkg::*;
#(
  parameter int          RING_BYTES = 2048,
  parameter logic [47:0] LOCAL_MAC  = 48'hAABBCCDDEEFF,
  localparam int         PTR_W      = $clog2(RING_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             crsDv,
  input  logic             rxErr,
  input  logic [1:0]       rxd,
  input  logic [PTR_W-1:0] swRdPtr,
  output logic             memWe,
  output logic [PTR_W-1:0] memAddr,
  output logic [7:0]       memData,
  output logic [PTR_W-1:0] wrPtr
);

  rxCtlT  ctl;
  rxStatT stat;

  rmii_rx_ctl u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .crsDv (crsDv),
    .rxErr (rxErr),
    .stat  (stat),
    .ctl   (ctl)
  );

  rmii_rx_dp #(
    .RING_BYTES (RING_BYTES),
    .LOCAL_MAC  (LOCAL_MAC),
    .PTR_W      (PTR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .crsDv   (crsDv),
    .rxd     (rxd),
    .swRdPtr (swRdPtr),
    .ctl     (ctl),
    .stat    (stat),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memData (memData),
    .wrPtr   (wrPtr)
  );

endmodule

// File: tb/rmii_rx_filter_test.sv
`timescale 1ns/1ps
module rmii_rx_filter_test;

  localparam int          RB  = 64;
  localparam int          PW  = 6;
  localparam logic [47:0] MAC = 48'hAABBCCDDEEFF;

  typedef logic [7:0] bq_t[$];

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          crsDv = 1'b0;
  logic          rxErr = 1'b0;
  logic [1:0]    rxd = 2'b00;
  logic [PW-1:0] swRdPtr = '0;
  logic          memWe;
  logic [PW-1:0] memAddr;
  logic [7:0]    memData;
  logic [PW-1:0] wrPtr;

  int checks = 0;
  int errors = 0;
  int expWr = 0;
  int rdPtr = 0;
  bit done = 1'b0;
  logic [7:0] shadow [RB];

  always #2 clk = ~clk;

  rmii_rx_filter #(.RING_BYTES(RB), .LOCAL_MAC(MAC)) uut (
    .clk(clk), .rstN(rstN), .crsDv(crsDv), .rxErr(rxErr), .rxd(rxd),
    .swRdPtr(swRdPtr), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .wrPtr(wrPtr)
  );

  function automatic int modr(input int v);
    return ((v % RB) + RB) % RB;
  endfunction

  function automatic logic [31:0] refCrc(input bq_t q, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bq_t withFcs(input bq_t q);
    bq_t r = q;
    logic [31:0] f = ~refCrc(q, q.size());
    for (int i = 0; i < 4; i++) r.push_back(f[8*i +: 8]);
    return r;
  endfunction

  function automatic bq_t mkFrame(input logic [47:0] dst, input int n, input int seed);
    bq_t q;
    for (int i = 0; i < 6; i++) q.push_back(dst[47-8*i -: 8]);
    for (int i = 0; i < n; i++) q.push_back(8'((seed * 37 + i * 11 + 5) & 8'hFF));
    return withFcs(q);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: compare the pointer and record writes at the falling edge.
  task automatic tick();
    @(negedge clk);
    check(int'(wrPtr) == expWr, "R4 wrPtr", int'(wrPtr), expWr);
    if (memWe) begin
      check(modr(int'(memAddr) - expWr) < modr(rdPtr - expWr - 1),
            "R3 write in free space", int'(memAddr), expWr);
      shadow[memAddr] = memData;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit err);
    for (int k = 0; k < 4; k++) begin
      tick();
      crsDv = 1'b1;
      rxErr = err;
      rxd   = b[2*k +: 2];
    end
  endtask

  task automatic sendFrame(input bq_t q, input int errAt, input int extra, input string req);
    int  start = expWr;
    int  len   = q.size();
    bit  macOk, fcsOk, ok;
    logic [31:0] f;
    for (int i = 0; i < 7; i++) sendByte(8'h55, 1'b0);
    sendByte(8'hD5, 1'b0);
    for (int i = 0; i < len; i++) sendByte(q[i], i == errAt);
    for (int i = 0; i < extra; i++) begin
      tick();
      rxd = 2'b00;
    end
    tick();
    crsDv = 1'b0;
    rxErr = 1'b0;
    rxd   = 2'b00;
    macOk = len >= 6;
    for (int i = 0; i < 6 && i < len; i++) if (q[i] != MAC[47-8*i -: 8]) macOk = 1'b0;
    fcsOk = 1'b0;
    if (len >= 4) begin
      f = ~refCrc(q, len - 4);
      fcsOk = {q[len-1], q[len-2], q[len-3], q[len-4]} == f;
    end
    ok = macOk && fcsOk && (errAt < 0) && (extra == 0) && (len >= 10) &&
         (len - 4 <= modr(rdPtr - expWr - 1));
    if (ok) expWr = modr(expWr + len - 4);
    for (int i = 0; i < 4; i++) tick();
    if (ok) begin
      for (int i = 0; i < len - 4; i++)
        check(shadow[modr(start + i)] == q[i], {req, " stored byte"},
              int'(shadow[modr(start + i)]), int'(q[i]));
    end else begin
      check(int'(wrPtr) == start, {req, " frame discarded"}, int'(wrPtr), start);
    end
  endtask

  task automatic setRd(input int v);
    tick();
    rdPtr   = v;
    swRdPtr = PW'(v);
  endtask

  initial begin
    #80000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bq_t q;
    for (int i = 0; i < RB; i++) shadow[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(wrPtr == '0, "R1 reset pointer", int'(wrPtr), 0);
    check(memWe == 1'b0, "R1 no write after reset", int'(memWe), 0);
    repeat (3) tick();

    // R2 / R4: good frame stored without lead-in, pointer advances by len-4.
    sendFrame(mkFrame(MAC, 32, 1), -1, 0, "R2");
    check(expWr == 38, "R4 advance amount", expWr, 38);

    // R5: foreign destination.
    sendFrame(mkFrame(48'hAABBCCDDEEFE, 10, 2), -1, 0, "R5");

    // R6: corrupted body byte.
    q = mkFrame(MAC, 12, 3);
    q[8] = q[8] ^ 8'h10;
    sendFrame(q, -1, 0, "R6");

    // R7: receive error mid-frame.
    sendFrame(mkFrame(MAC, 12, 4), 9, 0, "R7");

    // R9: too short, then a stray trailing dibit.
    q = {};
    for (int i = 0; i < 5; i++) q.push_back(MAC[47-8*i -: 8]);
    sendFrame(withFcs(q), -1, 0, "R9 short");
    sendFrame(mkFrame(MAC, 8, 5), -1, 1, "R9 partial byte");

    // R10 / R11: after drops, next frame lands at pointer and wraps.
    setRd(38);
    sendFrame(mkFrame(MAC, 44, 6), -1, 0, "R10 R11");
    check(expWr == 24, "R11 wrapped pointer", expWr, 24);

    // R8: free room 9; 10 bytes dropped, 9 bytes accepted.
    setRd(34);
    sendFrame(mkFrame(MAC, 4, 7), -1, 0, "R8 too big");
    sendFrame(mkFrame(MAC, 3, 8), -1, 0, "R8 exact fit");
    check(expWr == 33, "R8 ring full pointer", expWr, 33);

    setRd(33);
    sendFrame(mkFrame(MAC, 5, 9), -1, 0, "R2 after full");
    repeat (4) tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule